// File: doc/BRIEF.md
# E3 Receive Alarm and Interrupt Monitor

This block sits behind an E3 receive framer and turns per-frame summaries into two persistent alarm states: the Alarm Indication Signal (AIS) and the Far-End Receive Failure (FERF). For each frame, the framer gives a one-cycle frame-boundary strobe with two values: the number of zero bits counted in that frame and the value of the frame's A bit. An external AIS-pattern-detected input and the LOS and LOF states also come in from the framer.

Both alarms are set and cleared only after runs of consecutive frames. AIS is declared at once when a frame is short of zeros. It clears only after two frames in a row that are rich in zeros. The FERF persistence is 3 or 5 frames, chosen by a read/write field. Each alarm state is visible on a status register. AIS also drives a dedicated output pin. Changes of state are recorded in an interrupt status register whose bits clear on read. An interrupt output combines those bits with an enable mask.

Top module: `e3_alarm_monitor`

## Requirements
- R1: A frame strobe with a zero count below 8, or the AIS-pattern input being high in any cycle, sets the AIS state on the next clock edge. The same event restarts the AIS clearing run.
- R2: AIS clears only on the second consecutive frame with 8 or more zeros. A frame with fewer zeros, or the AIS-pattern input, restarts that count of two.
- R3: The AIS state drives `rxAisPin`. It also appears as bit 3 of the status register (address 1).
- R4: FERF is declared after N consecutive frames with A bit 1. N is 3 when status bit 4 is 0 and 5 when it is 1. A frame with A bit 0 restarts the run.
- R5: FERF clears after N consecutive frames with A bit 0, where N is the same selected value. A frame with A bit 1 restarts the run. The FERF state reads as bit 0 of the status register.
- R6: Status register layout: bit 0 is FERF, bit 3 is AIS, bit 4 is the FERF run select (read/write), bit 5 is LOS and bit 6 is LOF. Every other bit reads 0. A write to address 1 changes only bit 4.
- R7: Interrupt status register (address 3): bit 0 records an AIS change, bit 1 a LOS change, bit 2 a LOF change and bit 5 a FERF change. The remaining bits read 0. A read with `regRdEn` high clears the register.
- R8: An event that lands in the same cycle as a clearing read stays set after that read.
- R9: `irqOut` is high when any interrupt status bit is set together with its bit in the enable register (address 2, read/write).
- R10: After reset, both alarm states are 0, all run counters are 0, the FERF select is 3 frames, and the interrupt status and enable registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | One-cycle pulse per received frame |
| zeroCount | input | 11 | Zeros counted in the frame just ended |
| aBit | input | 1 | A bit of the frame just ended |
| aisPatternIn | input | 1 | External AIS pattern detected |
| losIn | input | 1 | Loss-of-signal state from the framer |
| lofIn | input | 1 | Loss-of-frame state from the framer |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears interrupt status) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` (combinational) |
| rxAisPin | output | 1 | AIS alarm output |
| irqOut | output | 1 | Combined, enabled interrupt request |

## Verification
A wrong AIS run counter shows up on `rxAisPin` one clock edge after the frame strobe that should have cleared or kept the alarm. It shows up no later than the second zero-rich frame. A wrong FERF counter or run select shows in status bit 0 on the third or fifth frame of a run. It shows in the same cycle as status bit 5 of the interrupt status register. Errors in clear-on-read or in keeping an event are visible on the first plain read after the clearing read, and on `irqOut` one edge after the event.

// File: rtl/e3am_pkg.sv
package e3am_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] ADDR_STATUS  = 4'h1;
  localparam logic [REG_AW-1:0] ADDR_IRQ_EN  = 4'h2;
  localparam logic [REG_AW-1:0] ADDR_IRQ_STS = 4'h3;

  // status register fields
  localparam int ST_FERF = 0;
  localparam int ST_AIS  = 3;
  localparam int ST_SEL  = 4;
  localparam int ST_LOS  = 5;
  localparam int ST_LOF  = 6;

  // interrupt status fields
  localparam int IS_AIS  = 0;
  localparam int IS_LOS  = 1;
  localparam int IS_LOF  = 2;
  localparam int IS_FERF = 5;
  localparam logic [REG_DW-1:0] IS_USED = 8'h27;

  typedef struct packed {
    logic frameLow;
    logic frameHigh;
    logic frameAOne;
    logic frameAZero;
    logic aisForce;
    logic rdIrq;
    logic wrCfg;
    logic wrIrqEn;
  } ctlStrobes_t;
endpackage

// File: rtl/e3am_ctrl.sv
module e3am_ctrl
  import e3am_pkg::*;
#(
  parameter int ZCW          = 11,
  parameter int AIS_ZERO_MIN = 8
) (
  input  logic              frameStrobe,
  input  logic [ZCW-1:0]    zeroCount,
  input  logic              aBit,
  input  logic              aisPatternIn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              aisState,
  input  logic              ferfState,
  input  logic              ferfSel,
  input  logic              losIn,
  input  logic              lofIn,
  input  logic [REG_DW-1:0] irqStat,
  input  logic [REG_DW-1:0] irqEn,
  output ctlStrobes_t       ctl,
  output logic [REG_DW-1:0] regRdData
);
  localparam logic [ZCW-1:0] ZMIN = ZCW'(AIS_ZERO_MIN);

  logic lowZero;
  assign lowZero = zeroCount < ZMIN;

  always_comb begin
    ctl            = '0;
    ctl.frameLow   = frameStrobe && lowZero;
    ctl.frameHigh  = frameStrobe && !lowZero;
    ctl.frameAOne  = frameStrobe && aBit;
    ctl.frameAZero = frameStrobe && !aBit;
    ctl.aisForce   = aisPatternIn;
    ctl.rdIrq      = regRdEn && (regAddr == ADDR_IRQ_STS);
    ctl.wrCfg      = regWrEn && (regAddr == ADDR_STATUS);
    ctl.wrIrqEn    = regWrEn && (regAddr == ADDR_IRQ_EN);
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_STATUS: begin
        regRdData[ST_FERF] = ferfState;
        regRdData[ST_AIS]  = aisState;
        regRdData[ST_SEL]  = ferfSel;
        regRdData[ST_LOS]  = losIn;
        regRdData[ST_LOF]  = lofIn;
      end
      ADDR_IRQ_EN:  regRdData = irqEn;
      ADDR_IRQ_STS: regRdData = irqStat & IS_USED;
      default:      regRdData = '0;
    endcase
  end
endmodule

// File: rtl/e3am_datapath.sv
module e3am_datapath
  import e3am_pkg::*;
#(
  parameter int AIS_CLR_FRAMES = 2,
  parameter int FERF_SHORT     = 3,
  parameter int FERF_LONG      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [REG_DW-1:0] wrData,
  input  logic              losIn,
  input  logic              lofIn,
  output logic              aisState,
  output logic              ferfState,
  output logic              ferfSel,
  output logic [REG_DW-1:0] irqStat,
  output logic [REG_DW-1:0] irqEn,
  output logic              irqOut
);
  localparam int ACW = $clog2(AIS_CLR_FRAMES + 1);
  localparam int FCW = $clog2(FERF_LONG + 1);
  localparam logic [ACW-1:0] ACLR_LAST = ACW'(AIS_CLR_FRAMES - 1);
  localparam logic [FCW-1:0] FSHORT_LAST = FCW'(FERF_SHORT - 1);
  localparam logic [FCW-1:0] FLONG_LAST  = FCW'(FERF_LONG - 1);

  logic [ACW-1:0] aisRun, aisRunNext;
  logic [FCW-1:0] ferfRun, ferfRunNext;
  logic aisNext, ferfNext;
  logic losPrev, lofPrev;
  logic [REG_DW-1:0] evMask, irqStatNext;
  logic ferfMismatch, ferfMatch;
  logic [FCW-1:0] ferfLast;
  logic evAny;

  // AIS run logic
  always_comb begin
    aisNext    = aisState;
    aisRunNext = aisRun;
    if (ctl.aisForce || ctl.frameLow) begin
      aisNext    = 1'b1;
      aisRunNext = '0;
    end else if (ctl.frameHigh && aisState) begin
      if (aisRun >= ACLR_LAST) begin
        aisNext    = 1'b0;
        aisRunNext = '0;
      end else begin
        aisRunNext = aisRun + 1'b1;
      end
    end
  end

  // FERF run logic
  assign ferfLast     = ferfSel ? FLONG_LAST : FSHORT_LAST;
  assign ferfMismatch = ferfState ? ctl.frameAZero : ctl.frameAOne;
  assign ferfMatch    = ferfState ? ctl.frameAOne  : ctl.frameAZero;

  always_comb begin
    ferfNext    = ferfState;
    ferfRunNext = ferfRun;
    if (ferfMismatch) begin
      if (ferfRun >= ferfLast) begin
        ferfNext    = !ferfState;
        ferfRunNext = '0;
      end else begin
        ferfRunNext = ferfRun + 1'b1;
      end
    end else if (ferfMatch) begin
      ferfRunNext = '0;
    end
  end

  // interrupt events
  always_comb begin
    evMask          = '0;
    evMask[IS_AIS]  = aisNext != aisState;
    evMask[IS_LOS]  = losIn != losPrev;
    evMask[IS_LOF]  = lofIn != lofPrev;
    evMask[IS_FERF] = ferfNext != ferfState;
  end
  assign evAny       = |evMask;
  assign irqStatNext = ((ctl.rdIrq ? '0 : irqStat) | evMask) & IS_USED;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aisState  <= 1'b0;
      aisRun    <= '0;
      ferfState <= 1'b0;
      ferfRun   <= '0;
      ferfSel   <= 1'b0;
      losPrev   <= 1'b0;
      lofPrev   <= 1'b0;
      irqStat   <= '0;
      irqEn     <= '0;
    end else begin
      aisState  <= aisNext;
      aisRun    <= aisRunNext;
      ferfState <= ferfNext;
      ferfRun   <= ferfRunNext;
      losPrev   <= losIn;
      lofPrev   <= lofIn;
      irqStat   <= irqStatNext;
      if (ctl.wrCfg)   ferfSel <= wrData[ST_SEL];
      if (ctl.wrIrqEn) irqEn   <= wrData;
    end
  end

  assign irqOut = |(irqStat & irqEn);

  // R1
  ais_declare_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.frameLow || ctl.aisForce) |=> aisState);

  // R2
  ais_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aisState) |-> ($past(ctl.frameHigh) && !$past(ctl.aisForce)));

  // R4
  ferf_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ferfState) |-> $past(ctl.frameAOne));

  // R5
  ferf_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ferfState) |-> $past(ctl.frameAZero));

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdIrq && !evAny) |=> (irqStat == '0));

  // R8
  irq_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aisNext != aisState) |=> irqStat[IS_AIS]);

  // R4
  ferf_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    ferfRun <= FLONG_LAST);
endmodule

// File: rtl/e3_alarm_monitor.sv
module e3_alarm_monitor
  import e3am_pkg::*;
#(
  parameter int ZCW            = 11,
  parameter int AIS_ZERO_MIN   = 8,
  parameter int AIS_CLR_FRAMES = 2,
  parameter int FERF_SHORT     = 3,
  parameter int FERF_LONG      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStrobe,
  input  logic [ZCW-1:0]    zeroCount,
  input  logic              aBit,
  input  logic              aisPatternIn,
  input  logic              losIn,
  input  logic              lofIn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_DW-1:0] regWrData,
  output logic [REG_DW-1:0] regRdData,
  output logic              rxAisPin,
  output logic              irqOut
);
  ctlStrobes_t ctl;
  logic aisState, ferfState, ferfSel;
  logic [REG_DW-1:0] irqStat, irqEn;

  e3am_ctrl #(.ZCW(ZCW), .AIS_ZERO_MIN(AIS_ZERO_MIN)) uCtrl (
    .frameStrobe(frameStrobe), .zeroCount(zeroCount), .aBit(aBit),
    .aisPatternIn(aisPatternIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .aisState(aisState), .ferfState(ferfState),
    .ferfSel(ferfSel), .losIn(losIn), .lofIn(lofIn), .irqStat(irqStat),
    .irqEn(irqEn), .ctl(ctl), .regRdData(regRdData)
  );

  e3am_datapath #(.AIS_CLR_FRAMES(AIS_CLR_FRAMES), .FERF_SHORT(FERF_SHORT),
                  .FERF_LONG(FERF_LONG)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(regWrData),
    .losIn(losIn), .lofIn(lofIn), .aisState(aisState),
    .ferfState(ferfState), .ferfSel(ferfSel), .irqStat(irqStat),
    .irqEn(irqEn), .irqOut(irqOut)
  );

  assign rxAisPin = aisState;
endmodule

// File: tb/sim_e3_alarm_monitor.sv
module sim_e3_alarm_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStrobe = 1'b0;
  logic [10:0] zeroCount = '0;
  logic aBit = 1'b0, aisPatternIn = 1'b0, losIn = 1'b0, lofIn = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic rxAisPin, irqOut;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  e3_alarm_monitor u0 (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .zeroCount(zeroCount),
    .aBit(aBit), .aisPatternIn(aisPatternIn), .losIn(losIn), .lofIn(lofIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .rxAisPin(rxAisPin),
    .irqOut(irqOut)
  );

  // {zeros[10:0], aBit, aisPattern, expAis, expFerf}
  localparam int NV = 13;
  localparam logic [14:0] VEC [NV] = '{
    {11'd20, 1'b0, 1'b0, 1'b0, 1'b0},
    {11'd3,  1'b1, 1'b0, 1'b1, 1'b0},
    {11'd20, 1'b1, 1'b0, 1'b1, 1'b0},
    {11'd3,  1'b1, 1'b0, 1'b1, 1'b1},
    {11'd8,  1'b0, 1'b0, 1'b1, 1'b1},
    {11'd8,  1'b1, 1'b0, 1'b0, 1'b1},
    {11'd9,  1'b0, 1'b0, 1'b0, 1'b1},
    {11'd9,  1'b0, 1'b0, 1'b0, 1'b1},
    {11'd9,  1'b0, 1'b0, 1'b0, 1'b0},
    {11'd7,  1'b0, 1'b0, 1'b1, 1'b0},
    {11'd30, 1'b0, 1'b1, 1'b1, 1'b0},
    {11'd30, 1'b0, 1'b0, 1'b1, 1'b0},
    {11'd30, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [10:0] z, input logic a, input logic pat);
    @(negedge clk);
    frameStrobe = 1'b1; zeroCount = z; aBit = a; aisPatternIn = pat;
    @(negedge clk);
    frameStrobe = 1'b0; aisPatternIn = 1'b0;
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // clearing read: data captured before the edge
  task automatic rdReg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    peek(4'h1, d); check("R10 status", d, 8'h00);
    peek(4'h3, d); check("R10 irq status", d, 8'h00);
    peek(4'h2, d); check("R10 irq enable", d, 8'h00);
    check("R10 pin", {7'b0, rxAisPin}, 8'h00);
    check("R10 irqOut", {7'b0, irqOut}, 8'h00);

    // R1 R2 R3 R4 R5 table of frames, FERF run select = 3
    for (int i = 0; i < NV; i++) begin
      frame(VEC[i][14:4], VEC[i][3], VEC[i][2]);
      check("R1/R2/R3 rxAisPin", {7'b0, rxAisPin}, {7'b0, VEC[i][1]});
      peek(4'h1, d);
      check("R4/R5 status", d & 8'h09, {4'b0, VEC[i][1], 2'b0, VEC[i][0]});
    end

    // R7 both alarm changes recorded, then cleared by read
    rdReg(4'h3, d); check("R7 irq bits", d, 8'h21);
    peek(4'h3, d);  check("R7 cleared", d, 8'h00);

    // R6 only bit 4 writable
    wrReg(4'h1, 8'hFF);
    peek(4'h1, d); check("R6 status write", d, 8'h10);

    // R4 five-frame select
    for (int i = 0; i < 4; i++) frame(11'd30, 1'b1, 1'b0);
    peek(4'h1, d); check("R4 sel5 after 4", d, 8'h10);
    frame(11'd30, 1'b1, 1'b0);
    peek(4'h1, d); check("R4 sel5 after 5", d, 8'h11);
    rdReg(4'h3, d); check("R7 ferf bit", d, 8'h20);

    // R8 event in the same cycle as a clearing read
    @(negedge clk);
    regAddr = 4'h3; regRdEn = 1'b1; aisPatternIn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0; aisPatternIn = 1'b0;
    peek(4'h3, d); check("R8 kept", d, 8'h01);
    check("R8 pin", {7'b0, rxAisPin}, 8'h01);

    // R9 interrupt output gated by enable
    check("R9 irqOut disabled", {7'b0, irqOut}, 8'h00);
    wrReg(4'h2, 8'h01);
    check("R9 irqOut enabled", {7'b0, irqOut}, 8'h01);
    rdReg(4'h3, d);
    check("R9 irqOut after clear", {7'b0, irqOut}, 8'h00);

    // R7 R6 LOS change
    @(negedge clk); losIn = 1'b1;
    peek(4'h3, d); check("R7 los change", d, 8'h02);
    peek(4'h1, d); check("R6 status los", d, 8'h39);
    check("R9 masked los", {7'b0, irqOut}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule